// File: doc/BRIEF.md
# Multi-Channel Tagged Debug Word FIFO

This block moves 32-bit words between a processor and an external debug probe over sixteen logical channels that share one transmit queue and one receive queue. The processor writes a word to one of sixteen transmit addresses. The address picks the channel, and the word travels through the transmit queue with that channel number attached. Words arriving from the probe carry their own channel number. The processor reads them from a single receive address, after checking the status register to see which channel the oldest waiting word belongs to.

A configuration register reports both queue depths. It also holds two independent interrupt mode fields, one for each direction. The single interrupt output is asserted whenever either direction's selected condition holds. On the probe side there is one valid/ready word port in each direction, each with a 4-bit channel tag. A full transmit queue never stalls the processor: a write that finds it full is discarded and latches a sticky overflow flag.

Top module: `dbgch_mailbox`

## Requirements
- R1: A bus write to offset 0x20 + 8*n (n = 0..15) queues the write data with channel tag n. Words leave on `prb_tx_data`/`prb_tx_chan` in write order, one per cycle in which `prb_tx_valid` and `prb_tx_ready` are both high. A write to any other offset in 0x20..0x9F (not a multiple of 8) queues nothing.
- R2: Status register (offset 0x10) flag bits: bit 0 is 1 when the transmit queue is full, bit 1 when it is empty, bit 2 when the receive queue is full, and bit 3 when it is empty. Bits 15:8 read 0.
- R3: A transmit write that finds the transmit queue full is discarded and sets bit 0 of the control register (offset 0x00). That bit stays set until a write to offset 0x00 with data bit 0 = 1. All other control bits read 0.
- R4: A probe word is accepted in each cycle where `prb_rx_valid` is high and the receive queue is not full. `prb_rx_ready` is low exactly when that queue is full.
- R5: A bus read of offset 0x18 returns the oldest received word and removes it. Status bits 7:4 always show the channel tag of the oldest received word, so after the read they show the tag of the next word.
- R6: A read of offset 0x18 while the receive queue is empty returns 0 and changes no queue state.
- R7: Status bits 31:24 give the transmit queue occupancy and bits 23:16 give the receive queue occupancy.
- R8: Configuration register (offset 0x08): bits 7:0 read the receive depth and bits 15:8 read the transmit depth. Bits 17:16 (receive mode) and 19:18 (transmit mode) are writable. All other bits read 0 and ignore writes.
- R9: Transmit interrupt condition by mode: 0 never; 1 when the transmit queue is empty; 2 when it is not full; 3 when its occupancy is at most one quarter of its depth.
- R10: Receive interrupt condition by mode: 0 never; 1 when the receive queue is full; 2 when it is not empty; 3 when four times its occupancy is at least three times its depth.
- R11: `irq_o` is the OR of the transmit condition and the receive condition. It follows the queue state and the modes with no extra register delay.
- R12: After reset both queues are empty, both modes are 0, the overflow flag is clear, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read cycle |
| irq_o | output | 1 | Interrupt request |
| prb_tx_valid | output | 1 | Transmit word available to probe |
| prb_tx_ready | input | 1 | Probe takes the transmit word |
| prb_tx_chan | output | 4 | Channel tag of transmit word |
| prb_tx_data | output | 32 | Transmit word |
| prb_rx_valid | input | 1 | Probe offers a word |
| prb_rx_ready | output | 1 | Receive queue can accept |
| prb_rx_chan | input | 4 | Channel tag of offered word |
| prb_rx_data | input | 32 | Offered word |

## Verification
The assertions check every cycle that each queue's occupancy moves by exactly its push and pop. They also check that neither queue is pushed when full or popped when empty, that a dropped transmit write always leaves the overflow flag set, that the flag stays set until it is cleared, and that an empty receive read returns zero. Channel tagging, word ordering through both queues, the quarter and three-quarter interrupt boundaries, and the read-only configuration fields depend on long histories of traffic. Only the bench's scenarios show them, as it compares every probe word, register read and interrupt level against its own queue model.

// File: rtl/dbgch_pkg.sv
package dbgch_pkg;

  localparam int NCH    = 16;
  localparam int CH_W   = 4;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 8'h18;
  localparam int               TX_SLOT0 = 4;   // 0x20 >> 3

  typedef enum logic [1:0] {
    TXI_OFF     = 2'd0,
    TXI_EMPTY   = 2'd1,
    TXI_NOTFULL = 2'd2,
    TXI_LOW     = 2'd3
  } tx_irq_mode_e;

  typedef enum logic [1:0] {
    RXI_OFF      = 2'd0,
    RXI_FULL     = 2'd1,
    RXI_NOTEMPTY = 2'd2,
    RXI_HIGH     = 2'd3
  } rx_irq_mode_e;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] chan;
  } tx_slot_t;

  // occupancy at or below a quarter of the depth
  function automatic logic is_low_water(int unsigned cnt, int unsigned depth);
    return cnt <= (depth / 4);
  endfunction

  // occupancy at or above three quarters of the depth
  function automatic logic is_high_water(int unsigned cnt, int unsigned depth);
    return (cnt * 4) >= (depth * 3);
  endfunction

  function automatic logic tx_irq_cond(tx_irq_mode_e mode, int unsigned cnt,
                                       int unsigned depth);
    case (mode)
      TXI_EMPTY:   return cnt == 0;
      TXI_NOTFULL: return cnt < depth;
      TXI_LOW:     return is_low_water(cnt, depth);
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic rx_irq_cond(rx_irq_mode_e mode, int unsigned cnt,
                                       int unsigned depth);
    case (mode)
      RXI_FULL:     return cnt == depth;
      RXI_NOTEMPTY: return cnt != 0;
      RXI_HIGH:     return is_high_water(cnt, depth);
      default:      return 1'b0;
    endcase
  endfunction

  // transmit window: one 8-byte slot per channel starting at 0x20
  function automatic tx_slot_t decode_tx(logic [ADDR_W-1:0] addr);
    tx_slot_t   r;
    logic [4:0] slot;
    slot   = addr[7:3];
    r.hit  = (addr[2:0] == 3'd0) && (slot >= 5'(TX_SLOT0)) &&
             (slot < 5'(TX_SLOT0 + NCH));
    r.chan = CH_W'(slot - 5'(TX_SLOT0));
    return r;
  endfunction

endpackage

// File: rtl/dbgch_fifo.sv
module dbgch_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  initial begin
    if ((1 << AW) != DEPTH) $error("dbgch_fifo: DEPTH must be a power of two");
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3 / R4: the queue is never written while full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R6: the queue is never read while empty
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  // R7: occupancy follows push and pop
  p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + 1'b1);
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> count == $past(count) - 1'b1);
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push == pop) |=> $stable(count));
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/dbgch_bus_dec.sv
module dbgch_bus_dec
  import dbgch_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_ctrl,
  output logic              wr_cfg,
  output logic              rd_rxd,
  output logic              wr_tx,
  output logic [CH_W-1:0]   tx_chan
);

  tx_slot_t slot;

  always_comb begin
    slot    = decode_tx(bus_addr);
    wr_ctrl = bus_sel &&  bus_wr && (bus_addr == OFF_CTRL);
    wr_cfg  = bus_sel &&  bus_wr && (bus_addr == OFF_CFG);
    rd_rxd  = bus_sel && !bus_wr && (bus_addr == OFF_RXD);
    wr_tx   = bus_sel &&  bus_wr && slot.hit;
    tx_chan = slot.chan;
  end

endmodule

// File: rtl/dbgch_irq.sv
module dbgch_irq
  import dbgch_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input  tx_irq_mode_e     tx_mode,
  input  rx_irq_mode_e     rx_mode,
  input  logic [TXC_W-1:0] tx_count,
  input  logic [RXC_W-1:0] rx_count,
  output logic             tx_cond,
  output logic             rx_cond,
  output logic             irq
);

  always_comb begin
    tx_cond = tx_irq_cond(tx_mode, 32'(tx_count), TX_DEPTH);
    rx_cond = rx_irq_cond(rx_mode, 32'(rx_count), RX_DEPTH);
    irq     = tx_cond | rx_cond;
  end

endmodule

// File: rtl/dbgch_mailbox.sv
module dbgch_mailbox
  import dbgch_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1),
  localparam int ENT_W = CH_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              prb_tx_valid,
  input  logic              prb_tx_ready,
  output logic [CH_W-1:0]   prb_tx_chan,
  output logic [WORD_W-1:0] prb_tx_data,
  input  logic              prb_rx_valid,
  output logic              prb_rx_ready,
  input  logic [CH_W-1:0]   prb_rx_chan,
  input  logic [WORD_W-1:0] prb_rx_data
);

  initial begin
    if (TX_DEPTH > 255 || RX_DEPTH > 255)
      $error("dbgch_mailbox: depths must fit an 8-bit field");
  end

  // decoded bus events
  logic            wr_ctrl, wr_cfg, rd_rxd, wr_tx;
  logic [CH_W-1:0] tx_chan;

  dbgch_bus_dec u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_ctrl (wr_ctrl),
    .wr_cfg  (wr_cfg),
    .rd_rxd  (rd_rxd),
    .wr_tx   (wr_tx),
    .tx_chan (tx_chan)
  );

  // queue events brought out as named wires
  logic             tx_push, tx_pop, tx_drop, rx_push, rx_pop, rx_empty_read;
  logic [ENT_W-1:0] tx_head, rx_head;
  logic [TXC_W-1:0] tx_count;
  logic [RXC_W-1:0] rx_count;
  logic             tx_full, tx_empty, rx_full, rx_empty;

  assign tx_push       = wr_tx && !tx_full;
  assign tx_drop       = wr_tx &&  tx_full;
  assign tx_pop        = prb_tx_ready && !tx_empty;
  assign rx_push       = prb_rx_valid && !rx_full;
  assign rx_pop        = rd_rxd && !rx_empty;
  assign rx_empty_read = rd_rxd &&  rx_empty;

  dbgch_fifo #(.W(ENT_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (tx_push),
    .push_data({tx_chan, bus_wdata}),
    .pop      (tx_pop),
    .head     (tx_head),
    .count    (tx_count),
    .full     (tx_full),
    .empty    (tx_empty)
  );

  dbgch_fifo #(.W(ENT_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rx_push),
    .push_data({prb_rx_chan, prb_rx_data}),
    .pop      (rx_pop),
    .head     (rx_head),
    .count    (rx_count),
    .full     (rx_full),
    .empty    (rx_empty)
  );

  assign prb_tx_valid = !tx_empty;
  assign prb_tx_chan  = tx_head[ENT_W-1 -: CH_W];
  assign prb_tx_data  = tx_head[WORD_W-1:0];
  assign prb_rx_ready = !rx_full;

  // control and configuration state
  logic         ovf_flag;
  tx_irq_mode_e tx_mode;
  rx_irq_mode_e rx_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      tx_mode  <= TXI_OFF;
      rx_mode  <= RXI_OFF;
    end else begin
      if (tx_drop)                     ovf_flag <= 1'b1;
      else if (wr_ctrl && bus_wdata[0]) ovf_flag <= 1'b0;
      if (wr_cfg) begin
        tx_mode <= tx_irq_mode_e'(bus_wdata[19:18]);
        rx_mode <= rx_irq_mode_e'(bus_wdata[17:16]);
      end
    end
  end

  logic tx_cond, rx_cond;

  dbgch_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_irq (
    .tx_mode (tx_mode),
    .rx_mode (rx_mode),
    .tx_count(tx_count),
    .rx_count(rx_count),
    .tx_cond (tx_cond),
    .rx_cond (rx_cond),
    .irq     (irq_o)
  );

  // read data
  logic [WORD_W-1:0] stat_word, cfg_word;

  always_comb begin
    stat_word = {8'(tx_count), 8'(rx_count), 8'h00,
                 rx_empty ? 4'h0 : rx_head[ENT_W-1 -: CH_W],
                 rx_empty, rx_full, tx_empty, tx_full};
    cfg_word  = {12'h000, tx_mode, rx_mode, 8'(TX_DEPTH), 8'(RX_DEPTH)};
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_CTRL: bus_rdata = {31'd0, ovf_flag};
        OFF_CFG:  bus_rdata = cfg_word;
        OFF_STAT: bus_rdata = stat_word;
        OFF_RXD:  bus_rdata = rx_empty ? '0 : rx_head[WORD_W-1:0];
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R3: a dropped write always leaves the flag set
  p_drop_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> ovf_flag);
  // R3: the flag only clears through the clear write
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_ctrl && bus_wdata[0])) |=> ovf_flag);
  // R6: an empty receive read returns zero and leaves the queue alone
  p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty_read |-> bus_rdata == '0);
  p_empty_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty_read && !prb_rx_valid) |=> rx_empty);
  // R4: the probe is refused exactly while the queue is full
  p_rx_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_rx_valid && rx_full && !rx_pop) |=> rx_full);
  // R11: interrupt low whenever both modes are off
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode == TXI_OFF && rx_mode == RXI_OFF) |-> !irq_o);

endmodule

// File: tb/dbgch_mailbox_tb.sv
module dbgch_mailbox_tb_top;

  localparam int TXD = 16;
  localparam int RXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        prb_tx_valid, prb_tx_ready = 1'b0;
  logic [3:0]  prb_tx_chan;
  logic [31:0] prb_tx_data;
  logic        prb_rx_valid = 1'b0, prb_rx_ready;
  logic [3:0]  prb_rx_chan = '0;
  logic [31:0] prb_rx_data = '0;

  always #5 clk = ~clk;

  dbgch_mailbox #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .prb_tx_valid(prb_tx_valid), .prb_tx_ready(prb_tx_ready),
    .prb_tx_chan(prb_tx_chan), .prb_tx_data(prb_tx_data),
    .prb_rx_valid(prb_rx_valid), .prb_rx_ready(prb_rx_ready),
    .prb_rx_chan(prb_rx_chan), .prb_rx_data(prb_rx_data)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model
  logic [35:0] txq[$];
  logic [35:0] rxq[$];
  bit          m_ovf = 0;
  logic [1:0]  m_txm = 0, m_rxm = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    int unsigned tc = txq.size(), rc = rxq.size();
    logic t, r;
    t = (m_txm == 1 && tc == 0) || (m_txm == 2 && tc != TXD) ||
        (m_txm == 3 && tc <= (TXD >> 2));
    r = (m_rxm == 1 && rc == RXD) || (m_rxm == 2 && rc > 0) ||
        (m_rxm == 3 && rc >= RXD - (RXD >> 2));
    return t || r;
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [3:0] hc = (rxq.size() > 0) ? rxq[0][35:32] : 4'h0;
    return {8'(txq.size()), 8'(rxq.size()), 8'h00, hc,
            rxq.size() == 0, rxq.size() == RXD, txq.size() == 0,
            txq.size() == TXD};
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic tx_write(logic [3:0] ch, logic [31:0] d);
    bus_write(8'h20 + 8'(ch) * 8'd8, d);
    if (txq.size() == TXD) m_ovf = 1;
    else txq.push_back({ch, d});
  endtask

  task automatic drain_one();
    logic v; logic [3:0] c; logic [31:0] d;
    @(negedge clk);
    prb_tx_ready = 1;
    #1 v = prb_tx_valid; c = prb_tx_chan; d = prb_tx_data;
    @(posedge clk); #1;
    prb_tx_ready = 0;
    if (txq.size() == 0) chk("R1 idle valid", 32'(v), 0);
    else begin
      logic [35:0] e = txq.pop_front();
      chk("R1 tx valid", 32'(v), 1);
      chk("R1 tx chan", 32'(c), 32'(e[35:32]));
      chk("R1 tx data", d, e[31:0]);
    end
  endtask

  task automatic probe_push(logic [3:0] ch, logic [31:0] d);
    logic rdy;
    @(negedge clk);
    prb_rx_valid = 1; prb_rx_chan = ch; prb_rx_data = d;
    #1 rdy = prb_rx_ready;
    @(posedge clk); #1;
    prb_rx_valid = 0;
    chk("R4 rx ready", 32'(rdy), 32'(rxq.size() != RXD));
    if (rxq.size() != RXD) rxq.push_back({ch, d});
  endtask

  task automatic rx_read();
    logic [31:0] d;
    bus_read(8'h18, d);
    if (rxq.size() == 0) chk("R6 empty read", d, 0);
    else begin
      logic [35:0] e = rxq.pop_front();
      chk("R5 rx data", d, e[31:0]);
    end
  endtask

  task automatic check_stat(string req);
    logic [31:0] d;
    bus_read(8'h10, d);
    chk(req, d, exp_stat());
  endtask

  task automatic check_irq(string req);
    @(negedge clk); #1;
    chk(req, 32'(irq_o), 32'(exp_irq()));
  endtask

  task automatic set_modes(logic [31:0] w);
    bus_write(8'h08, w);
    m_txm = w[19:18]; m_rxm = w[17:16];
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R12 reset state
    check_stat("R12 reset status");
    bus_read(8'h00, d); chk("R12 reset ovf", d, 0);
    bus_read(8'h08, d); chk("R12 reset cfg", d, {12'h0, 4'h0, 8'(TXD), 8'(RXD)});
    check_irq("R12 reset irq");

    // R8 read-only fields
    set_modes(32'hFFFF_FFFF);
    bus_read(8'h08, d); chk("R8 cfg readback", d, {12'h0, 4'hF, 8'(TXD), 8'(RXD)});
    set_modes(32'h0);

    // R1 unaligned transmit offset queues nothing
    bus_write(8'h24, 32'hDEAD_0001);
    check_stat("R1 unaligned ignored");

    // R1 tagging for every channel
    for (int c = 0; c < 16; c++) tx_write(4'(c), 32'hA500_0000 + 32'(c));
    check_stat("R2 tx full flags");
    bus_read(8'h00, d); chk("R3 no ovf yet", d, 0);
    // R3 overflow
    tx_write(4'd7, 32'hBAD0_BAD0);
    check_stat("R3 dropped count");
    bus_read(8'h00, d); chk("R3 ovf set", d, 1);
    bus_write(8'h00, 32'h0); bus_read(8'h00, d); chk("R3 ovf kept on 0", d, 1);
    bus_write(8'h00, 32'h1); m_ovf = 0;
    bus_read(8'h00, d); chk("R3 ovf cleared", d, 0);

    // R9 low-water boundary: drain to 5 then 4
    set_modes(32'h000C_0000);
    while (txq.size() > 5) drain_one();
    check_irq("R9 near empty at 5");
    drain_one();
    check_irq("R9 near empty at 4");
    set_modes(32'h0004_0000); check_irq("R9 empty mode nonempty");
    while (txq.size() > 0) drain_one();
    check_irq("R9 empty mode empty");
    drain_one();

    // R10 high-water boundary and R5 channel head
    set_modes(32'h0003_0000);
    for (int i = 0; i < 11; i++) probe_push(4'(15 - i), 32'hC000_0000 + 32'(i));
    check_irq("R10 near full at 11");
    probe_push(4'd9, 32'hC000_00FF);
    check_irq("R10 near full at 12");
    check_stat("R5 head chan");
    rx_read();
    check_stat("R5 head chan advanced");
    while (rxq.size() < RXD) probe_push(4'd2, 32'h1111_0000 + 32'(rxq.size()));
    probe_push(4'd3, 32'h2222_2222);
    set_modes(32'h0001_0000); check_irq("R10 full mode");
    set_modes(32'h0009_0000); check_irq("R11 or of both");
    while (rxq.size() > 0) rx_read();
    rx_read();
    check_stat("R6 empty after read");

    // constrained random traffic
    for (int it = 0; it < 3000; it++) begin
      int unsigned op = $urandom_range(99);
      if (op < 30)      tx_write(4'($urandom), $urandom);
      else if (op < 50) drain_one();
      else if (op < 75) probe_push(4'($urandom), $urandom);
      else if (op < 90) rx_read();
      else if (op < 95) check_stat("R7 random status");
      else begin
        set_modes($urandom);
        bus_read(8'h00, d); chk("R3 random ovf", d, 32'(m_ovf));
      end
      check_irq("R11 random irq");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule